// File: doc/BRIEF.md
# Programmable Binary-Stage Timer

A sixteen-stage binary counter advanced by a single-cycle tick enable in the system clock domain. A two-bit time select picks one of four counter stages. The chosen stage drives the single output, either as a continuous square wave or as a one-time transition that marks the end of a timed interval. The tick enable replaces a free-running oscillator, so a slow external clock can be fed straight into it.

A polarity input sets the output level while the block is held in reset. The same input inverts the output in both operating modes. Two sources clear the counter synchronously. The first is an active-high master reset. The second is a power-on reset request, which a disable input can mask. In single-cycle mode, the block re-arms only on a reset or when the mode input changes level.

Top module: `ptmr_timer`

## Requirements
- R1: The counter advances by exactly one on each rising clock edge where `tick_en_i` is 1 and no clear is active. It holds its value on every other edge.
- R2: The stage is chosen by `{sel_a_i, sel_b_i}`. 2'b10 selects stage 8 (period 256 ticks). 2'b01 selects stage 10 (period 1024 ticks). 2'b00 selects stage 13 (period 8192 ticks). 2'b11 selects stage 16 (period 65536 ticks). Stage k is counter bit k-1.
- R3: While `mreset_i` is 1, the next edge clears the counter and the single-cycle latch, whatever they hold, and no counting takes place.
- R4: When `por_req_i` is 1 and `por_dis_i` is 0, the counter and latch clear exactly as for the master reset. When `por_dis_i` is 1, `por_req_i` has no effect.
- R5: While a master reset or an unmasked power-on request is asserted, `out_o` equals `pol_i`.
- R6: With `mode_i`=1 (recycle), `out_o` equals `pol_i` XOR the selected counter bit. This gives a square wave whose period is 2^n ticks.
- R7: With `mode_i`=0 (single cycle), `out_o` flips away from `pol_i` on the edge where the 2^(n-1)-th tick since the last clear is counted. It then holds that level, whatever further ticks arrive.
- R8: A change in the level of `mode_i` is seen against a registered copy. On the following edge, that change clears the counter and the latch, which re-arms single-cycle operation.
- R9: While `rst_ni` is 0, the counter, the latch and the mode history are cleared asynchronously, and `out_o` equals `pol_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Count-advance enable, one cycle per tick |
| mreset_i | input | 1 | Master reset, active high, synchronous |
| por_req_i | input | 1 | Power-on reset request |
| por_dis_i | input | 1 | 1 masks the power-on reset request |
| sel_a_i | input | 1 | Time select, upper bit |
| sel_b_i | input | 1 | Time select, lower bit |
| pol_i | input | 1 | Output level while in reset; output inversion |
| mode_i | input | 1 | 1 = recycle, 0 = single cycle |
| out_o | output | 1 | Timer output |

## Verification
A counter that drops or repeats a tick moves the edges of the recycle square wave. In single-cycle mode it moves the single flip. The error shows at the next transition of the selected stage: within 128 ticks for stage 8 and within 32768 ticks for stage 16. A latch that fails to hold, or a re-arm that fails to clear it, shows on `out_o` in the cycle after the faulty edge. For this reason the bench compares the output on every cycle against an independent model, instead of only at the expected transitions.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic [1:0] {
    SEL_MID      = 2'b00,
    SEL_SHORT    = 2'b01,
    SEL_SHORTEST = 2'b10,
    SEL_LONGEST  = 2'b11
  } tap_sel_e;

  typedef enum logic {
    MODE_SINGLE  = 1'b0,
    MODE_RECYCLE = 1'b1
  } run_mode_e;
endpackage

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         adv_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] carry;

  // ripple-equivalent toggle chain: stage k flips when all lower stages are 1
  for (genvar k = 0; k < W; k++) begin : g_stage
    if (k == 0) begin : g_lsb
      assign carry[k] = 1'b1;
    end else begin : g_up
      assign carry[k] = carry[k-1] & cnt_q[k-1];
    end
    assign cnt_nxt_o[k] = cnt_q[k] ^ carry[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (adv_i)  cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ptmr_tap_sel.sv
module ptmr_tap_sel import ptmr_pkg::*; #(
  parameter int unsigned W      = 16,
  parameter int unsigned TAP_00 = 13,
  parameter int unsigned TAP_01 = 10,
  parameter int unsigned TAP_10 = 8,
  parameter int unsigned TAP_11 = 16
) (
  input  tap_sel_e     sel_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cnt_nxt_i,
  output logic         tap_o,
  output logic         tap_nxt_o
);
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [IW-1:0] IDX_00 = IW'(TAP_00 - 1);
  localparam logic [IW-1:0] IDX_01 = IW'(TAP_01 - 1);
  localparam logic [IW-1:0] IDX_10 = IW'(TAP_10 - 1);
  localparam logic [IW-1:0] IDX_11 = IW'(TAP_11 - 1);

  logic [IW-1:0] idx;

  // encoding is not monotonic in period; keep the explicit map
  always_comb begin
    unique case (sel_i)
      SEL_MID:      idx = IDX_00;
      SEL_SHORT:    idx = IDX_01;
      SEL_SHORTEST: idx = IDX_10;
      default:      idx = IDX_11;
    endcase
  end

  assign tap_o     = cnt_i[idx];
  assign tap_nxt_o = cnt_nxt_i[idx];
endmodule

// File: rtl/ptmr_one_shot.sv
module ptmr_one_shot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  input  logic tap_nxt_i,
  output logic fired_o
);
  logic fired_q;

  // set on the edge the selected stage first goes high; sticky until clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 fired_q <= 1'b0;
    else if (clr_i)              fired_q <= 1'b0;
    else if (adv_i && tap_nxt_i) fired_q <= 1'b1;
  end

  assign fired_o = fired_q;
endmodule

// File: rtl/ptmr_mode_watch.sv
module ptmr_mode_watch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  output logic chg_o
);
  logic mode_q;
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      mode_q <= mode_i;
      seen_q <= 1'b1;
    end
  end

  // no history right after reset: first sampled level is not a change
  assign chg_o = seen_q & (mode_i ^ mode_q);
endmodule

// File: rtl/ptmr_timer.sv
module ptmr_timer import ptmr_pkg::*; #(
  parameter int unsigned STAGES = 16,
  parameter int unsigned TAP_00 = 13,
  parameter int unsigned TAP_01 = 10,
  parameter int unsigned TAP_10 = 8,
  parameter int unsigned TAP_11 = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_en_i,
  input  logic mreset_i,
  input  logic por_req_i,
  input  logic por_dis_i,
  input  logic sel_a_i,
  input  logic sel_b_i,
  input  logic pol_i,
  input  logic mode_i,
  output logic out_o
);
  logic [STAGES-1:0] cnt;
  logic [STAGES-1:0] cnt_nxt;
  logic              tap_bit;
  logic              tap_nxt;
  logic              fired;
  logic              mode_chg;
  logic              rst_any;
  logic              clr;
  logic              adv;
  tap_sel_e          sel;

  assign rst_any = mreset_i | (por_req_i & ~por_dis_i);
  assign clr     = rst_any | mode_chg;
  assign adv     = tick_en_i & ~clr;
  assign sel     = tap_sel_e'({sel_a_i, sel_b_i});

  ptmr_mode_watch i_mode_watch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .chg_o  (mode_chg)
  );

  ptmr_counter #(.W(STAGES)) i_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .adv_i     (adv),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt)
  );

  ptmr_tap_sel #(
    .W(STAGES), .TAP_00(TAP_00), .TAP_01(TAP_01), .TAP_10(TAP_10), .TAP_11(TAP_11)
  ) i_tap_sel (
    .sel_i     (sel),
    .cnt_i     (cnt),
    .cnt_nxt_i (cnt_nxt),
    .tap_o     (tap_bit),
    .tap_nxt_o (tap_nxt)
  );

  ptmr_one_shot i_one_shot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .adv_i     (adv),
    .tap_nxt_i (tap_nxt),
    .fired_o   (fired)
  );

  always_comb begin
    if (rst_any)                           out_o = pol_i;
    else if (run_mode_e'(mode_i) == MODE_RECYCLE) out_o = pol_i ^ tap_bit;
    else                                   out_o = pol_i ^ fired;
  end
endmodule

// File: rtl/ptmr_timer_chk.sv
module ptmr_timer_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_en_i,
  input logic         mreset_i,
  input logic         por_req_i,
  input logic         por_dis_i,
  input logic         pol_i,
  input logic         out_o,
  input logic         rst_any,
  input logic         mode_chg,
  input logic         fired,
  input logic [W-1:0] cnt
);
  a_r1_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_en_i && !rst_any && !mode_chg) |=> (cnt == $past(cnt)));

  a_r3_mr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreset_i |=> (cnt == '0 && !fired));

  a_r4_por_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_req_i && !por_dis_i) |=> (cnt == '0));

  a_r4_por_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_req_i && por_dis_i && !mreset_i && !mode_chg && tick_en_i)
      |=> (cnt == $past(cnt) + W'(1)));

  a_r5_reset_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreset_i |-> (out_o == pol_i));

  a_r7_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fired && !rst_any && !mode_chg) |=> fired);

  a_r8_mode_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> (cnt == '0 && !fired));
endmodule

bind ptmr_timer ptmr_timer_chk #(.W(STAGES)) i_ptmr_timer_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_en_i (tick_en_i),
  .mreset_i  (mreset_i),
  .por_req_i (por_req_i),
  .por_dis_i (por_dis_i),
  .pol_i     (pol_i),
  .out_o     (out_o),
  .rst_any   (rst_any),
  .mode_chg  (mode_chg),
  .fired     (fired),
  .cnt       (cnt)
);

// File: tb/test_ptmr_timer.sv
`timescale 1ns/1ps
module test_ptmr_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, mr = 1'b0, por = 1'b0, dis = 1'b1;
  logic sa = 1'b1, sb = 1'b0, pol = 1'b1, mode = 1'b1;
  logic out;

  always #10 clk = ~clk;

  ptmr_timer i_ptmr_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick), .mreset_i(mr),
    .por_req_i(por), .por_dis_i(dis), .sel_a_i(sa), .sel_b_i(sb),
    .pol_i(pol), .mode_i(mode), .out_o(out)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  // reference state, built from the requirements
  int unsigned m_cnt = 0;
  bit m_fired = 1'b0, m_mode_q = 1'b0, m_seen = 1'b0;

  function automatic int tap_of(bit a, bit b);
    case ({a, b})
      2'b00:   return 13;
      2'b01:   return 10;
      2'b10:   return 8;
      default: return 16;
    endcase
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s out=%0b exp=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: apply inputs for one edge, predict the output after it
  task automatic step(input bit t, input bit m, input bit p, input bit d,
                      input bit a, input bit b, input bit pl, input bit md,
                      input string tag);
    bit rst_any, chg;
    int n;
    int unsigned nxt;
    @(negedge clk);
    tick = t; mr = m; por = p; dis = d; sa = a; sb = b; pol = pl; mode = md;
    n = tap_of(a, b);
    rst_any = m | (p & ~d);
    chg = m_seen & (md != m_mode_q);
    nxt = (m_cnt + 1) & 32'hFFFF;
    if (rst_any || chg) begin
      m_cnt = 0; m_fired = 1'b0;
    end else if (t) begin
      if (nxt[n-1]) m_fired = 1'b1;
      m_cnt = nxt;
    end
    m_mode_q = md; m_seen = 1'b1;
    exp_q.push_back(rst_any ? pl : (md ? (pl ^ m_cnt[n-1]) : (pl ^ m_fired)));
    tag_q.push_back(tag);
  endtask

  task automatic run(input int cyc, input int per, input bit a, input bit b,
                     input bit pl, input bit md, input string tag);
    for (int i = 0; i < cyc; i++)
      step((i % per) == 0, 1'b0, 1'b0, 1'b1, a, b, pl, md, tag);
  endtask

  // monitor: compare a quarter period after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) check(out, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9: asynchronous reset state, output at polarity level
    repeat (3) @(negedge clk);
    check(out, 1'b1, "R9 reset pol=1");
    pol = 1'b0;
    #1 check(out, 1'b0, "R9 reset pol=0");
    rst_n = 1'b1;

    // R2 R6: recycle, stage 8, ticks every cycle
    run(600, 1, 1'b1, 1'b0, 1'b0, 1'b1, "R2_R6 stage8");
    // R3 R5: master reset held with ticks; counting halted
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R3_R5 mreset");
    // R1: gapped ticks, stage 10, inverted polarity
    run(2600, 2, 1'b0, 1'b1, 1'b1, 1'b1, "R1_R2 stage10");
    // R4: unmasked power-on request clears, masked one ignored
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R4_R5 por");
    run(700, 1, 1'b0, 1'b1, 1'b1, 1'b1, "R4 after por");
    for (int i = 0; i < 600; i++) step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R4 por masked");
    // R2 R6: stage 13
    run(9000, 1, 1'b0, 1'b0, 1'b0, 1'b1, "R2_R6 stage13");
    // R2 R6: stage 16
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R3 clear");
    run(66000, 1, 1'b1, 1'b1, 1'b0, 1'b1, "R2_R6 stage16");

    // R8 R7: switch to single cycle, stage 8; flip at 128 ticks then hold past wrap
    run(700, 1, 1'b1, 1'b0, 1'b0, 1'b0, "R7_R8 single stage8");
    // R3: master reset re-arms single cycle
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3 rearm");
    run(300, 3, 1'b1, 1'b0, 1'b0, 1'b0, "R7 single gapped");
    // R8: a mode pulse re-arms
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R8 mode up");
    run(400, 1, 1'b1, 1'b0, 1'b0, 1'b0, "R8 rearmed");
    // R7: stage 10, polarity 1, gapped ticks
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R5 clear pol1");
    run(2500, 3, 1'b0, 1'b1, 1'b1, 1'b0, "R7 single stage10");

    repeat (3) @(posedge clk);
    #6;
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule